// File: doc/BRIEF.md
# Grouped-Read Synchronous FIFO

This block is a single-clock FIFO with a reader that sends out stored words only in groups of four. A producer offers one word per cycle with a write enable. The burst reader watches the FIFO's occupancy count. When at least four words are stored, it asserts the read request for exactly four consecutive cycles. The four words leave the block back to back, each marked by an output-valid flag.

Writes, reads and the occupancy count all run on one shared clock, so the count is never stale. A group therefore cannot run the FIFO dry partway through. No read is ever issued to an empty FIFO, and no word is ever repeated on the output.

The storage depth is a power of two of at least 8. The depth and the data width are parameters. A synchronous active-high reset returns the block to its empty, idle state.

Top module: `burst_fifo`

## Requirements
- R1: A group starts (read request rises) only in the cycle after a cycle in which the occupancy count was 4 or more. While fewer than four words are stored, the read request stays low and no word is output.
- R2: Each group holds the read request high for exactly four consecutive cycles. After the fourth cycle the request is low for at least one cycle. The next group may start in the cycle after that if the count is still 4 or more.
- R3: The read request is never high while `empty` is high. The sticky `underflow` flag, which is set by a read request while empty, stays low in all operation.
- R4: The occupancy count `level` rises by one on a cycle with only an accepted write. It falls by one on a cycle with only a read. It holds when both happen, or neither. `full` is high exactly when `level` equals DEPTH, and `empty` is high exactly when `level` is 0.
- R5: A write presented while `full` is high is dropped, and stored contents are unchanged. It sets the sticky `overflow` flag, which stays high until reset.
- R6: Words leave on `outData` in the order they were accepted. `outValid` is high in the cycle right after each cycle in which the read request was high.
- R7: A synchronous active-high reset clears both pointers, the count, both sticky flags, `outValid` and the reader state. After reset, `empty` is 1, `full` is 0 and `level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for writes and reads |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write enable for `wrData` |
| wrData | input | WIDTH | Word to store |
| rdReq | output | 1 | FIFO read request driven by the burst reader |
| outValid | output | 1 | `outData` holds a word read in the previous cycle |
| outData | output | WIDTH | Output word |
| level | output | $clog2(DEPTH)+1 | Current occupancy count |
| full | output | 1 | FIFO holds DEPTH words |
| empty | output | 1 | FIFO holds no words |
| overflow | output | 1 | Sticky: a write arrived while full |
| underflow | output | 1 | Sticky: a read was requested while empty |

## Verification
The bench stops with exactly three words stored to show that a reader acting on an early count would start a group and then read past empty. Such a reader would repeat the last word, which the scoreboard catches as a duplicate or out-of-order item, and the underflow flag would rise. A continuous write stream against the four-of-five-cycle drain drives the FIFO full. A design that stored a word while full would corrupt the order seen by the scoreboard, and a non-sticky overflow flag would drop back. Back-to-back groups check the one-cycle gap and the four-cycle request length. A reset in the middle of a group must leave no stray valid word and no leftover count.

// File: rtl/burst_fifo_pkg.sv
package burst_fifo_pkg;

  typedef enum logic {
    RD_IDLE  = 1'b0,
    RD_BURST = 1'b1
  } rdState_e;

  typedef struct packed {
    logic rdReq;
  } ctrlStrobes_t;

endpackage

// File: rtl/burst_fifo_datapath.sv
module burst_fifo_datapath
  import burst_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  ctrlStrobes_t     strobes,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  output logic [AW:0]      level,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [AW:0]      count;
  logic             wrFire;
  logic             rdFire;

  assign full   = (count == (AW+1)'(DEPTH));
  assign empty  = (count == '0);
  assign wrFire = wrEn && !full;
  assign rdFire = strobes.rdReq && !empty;
  assign level  = count;

  // storage array: written only, no reset needed
  always_ff @(posedge clk) begin
    if (wrFire) store[wrPtr] <= wrData;
  end

  // pointers wrap naturally because DEPTH is a power of two
  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (wrFire) wrPtr <= wrPtr + 1'b1;
      if (rdFire) rdPtr <= rdPtr + 1'b1;
    end
  end

  // exact same-clock occupancy counter
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case ({wrFire, rdFire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // registered output word, one cycle behind the request
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= rdFire;
      if (rdFire) outData <= store[rdPtr];
    end
  end

  // sticky error flags
  always_ff @(posedge clk) begin
    if (rst) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (wrEn && full)           overflow  <= 1'b1;
      if (strobes.rdReq && empty) underflow <= 1'b1;
    end
  end

endmodule

// File: rtl/burst_fifo_ctrl.sv
module burst_fifo_ctrl
  import burst_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int GROUP = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(GROUP)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [AW:0]  level,
  output ctrlStrobes_t strobes
);

  rdState_e       state;
  rdState_e       stateNext;
  logic [BW-1:0]  beat;
  logic [BW-1:0]  beatNext;
  logic           enough;

  assign enough = (level >= (AW+1)'(GROUP));

  always_comb begin
    stateNext = state;
    beatNext  = beat;
    unique case (state)
      RD_IDLE: begin
        beatNext = '0;
        if (enough) stateNext = RD_BURST;
      end
      RD_BURST: begin
        if (beat == BW'(GROUP - 1)) begin
          stateNext = RD_IDLE;
          beatNext  = '0;
        end else begin
          beatNext = beat + 1'b1;
        end
      end
      default: begin
        stateNext = RD_IDLE;
        beatNext  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RD_IDLE;
      beat  <= '0;
    end else begin
      state <= stateNext;
      beat  <= beatNext;
    end
  end

  assign strobes.rdReq = (state == RD_BURST);

endmodule

// File: rtl/burst_fifo.sv
module burst_fifo
  import burst_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             rdReq,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  output logic [AW:0]      level,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow
);

  localparam int GROUP = 4;

  ctrlStrobes_t strobes;

  burst_fifo_ctrl #(
    .DEPTH(DEPTH),
    .GROUP(GROUP)
  ) ctrlInst (
    .clk     (clk),
    .rst     (rst),
    .level   (level),
    .strobes (strobes)
  );

  burst_fifo_datapath #(
    .WIDTH(WIDTH),
    .DEPTH(DEPTH)
  ) dpInst (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .strobes   (strobes),
    .outValid  (outValid),
    .outData   (outData),
    .level     (level),
    .full      (full),
    .empty     (empty),
    .overflow  (overflow),
    .underflow (underflow)
  );

  assign rdReq = strobes.rdReq;

endmodule

// File: rtl/burst_fifo_checker.sv
module burst_fifo_checker #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst,
  input logic        wrEn,
  input logic        rdReq,
  input logic        outValid,
  input logic [AW:0] level,
  input logic        full,
  input logic        empty,
  input logic        overflow,
  input logic        underflow
);

  logic [2:0] runLen;

  always_ff @(posedge clk) begin
    if (rst)        runLen <= '0;
    else if (rdReq) runLen <= runLen + 1'b1;
    else            runLen <= '0;
  end

  // R1: a group begins only after the count reached four
  a_r1_start_threshold: assert property (@(posedge clk) disable iff (rst)
    ($rose(rdReq) && !$past(rst)) |-> ($past(level) >= (AW+1)'(4)));

  // R2: request high for exactly four cycles
  a_r2_group_len: assert property (@(posedge clk) disable iff (rst)
    ($fell(rdReq) && !$past(rst)) |-> (runLen == 3'd4));

  a_r2_no_long_group: assert property (@(posedge clk) disable iff (rst)
    (runLen <= 3'd4));

  // R3: never read an empty FIFO
  a_r3_no_read_empty: assert property (@(posedge clk) disable iff (rst)
    rdReq |-> !empty);

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    !underflow);

  // R4: count steps
  a_r4_level_up: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !full && !rdReq) |=> (level == $past(level) + 1'b1));

  a_r4_level_down: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && rdReq && !empty) |=> (level == $past(level) - 1'b1));

  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R5: overflow is sticky
  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R6: valid trails the request by one cycle
  a_r6_valid_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (outValid == $past(rdReq)));

endmodule

bind burst_fifo burst_fifo_checker #(.DEPTH(DEPTH)) chk (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .rdReq     (rdReq),
  .outValid  (outValid),
  .level     (level),
  .full      (full),
  .empty     (empty),
  .overflow  (overflow),
  .underflow (underflow)
);

// File: tb/burst_fifo_test.sv
module burst_fifo_test;

  localparam int WIDTH = 16;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wrEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic             rdReq;
  logic             outValid;
  logic [WIDTH-1:0] outData;
  logic [AW:0]      level;
  logic             full;
  logic             empty;
  logic             overflow;
  logic             underflow;

  burst_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .rdReq(rdReq), .outValid(outValid), .outData(outData),
    .level(level), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int modelLevel = 0;
  bit overflowExp = 1'b0;
  bit prevRd = 1'b0;
  bit lastRd = 1'b0;
  int lastLevel = 0;
  int runLen = 0;
  int totalValid = 0;
  logic [WIDTH-1:0] seed = 16'h1000;
  logic [WIDTH-1:0] expQ[$];
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, updated on the edge from the pre-edge values
  always @(posedge clk) begin
    if (rst) begin
      modelLevel  = 0;
      overflowExp = 1'b0;
      prevRd      = 1'b0;
      expQ.delete();
    end else begin
      prevRd = rdReq;
      if (wrEn && modelLevel == DEPTH) overflowExp = 1'b1;
      if (wrEn && modelLevel < DEPTH) begin
        expQ.push_back(wrData);
        if (!(rdReq && modelLevel > 0)) modelLevel++;
      end else if (rdReq && modelLevel > 0) begin
        modelLevel--;
      end
    end
  end

  // monitor: compares outputs between edges
  always @(negedge clk) begin
    if (rst) begin
      runLen = 0; lastRd = 1'b0; lastLevel = 0;
    end else if (!done) begin
      check(int'(level) == modelLevel, "R4", "level", level, modelLevel);
      check(full == (modelLevel == DEPTH), "R4", "full", full, modelLevel == DEPTH);
      check(empty == (modelLevel == 0), "R4", "empty", empty, modelLevel == 0);
      check(overflow == overflowExp, "R5", "overflow", overflow, overflowExp);
      check(!(rdReq && empty), "R3", "read while empty", rdReq, 0);
      check(!underflow, "R3", "underflow", underflow, 0);
      check(outValid == prevRd, "R6", "outValid lag", outValid, prevRd);
      if (rdReq && !lastRd)
        check(lastLevel >= 4, "R1", "start level", lastLevel, 4);
      if (rdReq) runLen++;
      else begin
        if (lastRd) check(runLen == 4, "R2", "group length", runLen, 4);
        runLen = 0;
      end
      if (outValid) begin
        totalValid++;
        if (expQ.size() == 0) check(1'b0, "R6", "unexpected word", outData, 0);
        else begin
          logic [WIDTH-1:0] e;
          e = expQ.pop_front();
          check(outData == e, "R6", "data order", outData, e);
        end
      end
      lastRd = rdReq;
      lastLevel = int'(level);
    end
  end

  task automatic writeWords(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrData = seed; seed++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        wrEn = 1'b0;
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20000 * 10);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R7: reset state
    check(level == 0, "R7", "reset level", level, 0);
    check(empty == 1'b1, "R7", "reset empty", empty, 1);
    check(full == 1'b0, "R7", "reset full", full, 0);
    check(outValid == 1'b0, "R7", "reset outValid", outValid, 0);
    check(!overflow && !underflow, "R7", "reset flags", {overflow, underflow}, 0);

    // R1: three words must not trigger a group
    writeWords(3, 0);
    idle(10);
    check(totalValid == 0, "R1", "no output below four", totalValid, 0);
    check(int'(level) == 3, "R1", "three held", level, 3);

    // R1/R2: fourth word releases one group
    writeWords(1, 0);
    idle(10);
    check(totalValid == 4, "R2", "one group out", totalValid, 4);
    check(empty == 1'b1, "R2", "drained", empty, 1);

    // R5: continuous writes overrun the four-of-five drain
    writeWords(50, 0);
    check(overflow == 1'b1, "R5", "overflow raised", overflow, 1);
    idle(30);
    check(overflow == 1'b1, "R5", "overflow sticky", overflow, 1);
    check(int'(level) < 4 && int'(level) == expQ.size(), "R1", "leftover held",
          level, expQ.size());

    // R2: spaced writes, back-to-back groups
    writeWords(20, 1);
    idle(20);

    // R7: reset in the middle of a group
    writeWords(8, 0);
    idle(2);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(level == 0, "R7", "mid reset level", level, 0);
    check(overflow == 1'b0, "R7", "mid reset overflow", overflow, 0);
    check(outValid == 1'b0, "R7", "mid reset outValid", outValid, 0);
    idle(3);
    check(rdReq == 1'b0, "R7", "reader idle", rdReq, 0);

    writeWords(4, 0);
    idle(10);
    check(expQ.size() == 0, "R6", "all words out", expQ.size(), 0);
    finish();
  end

endmodule